// File: doc/BRIEF.md
# SPI Serial EEPROM Array Reader

This block is the slave-side read path of a small serial EEPROM that sits on an SPI bus in mode 0. The bus signals are brought into the system clock domain, and the block recognises the array-read command. It then assembles a byte address and streams bytes from an on-chip byte-wide memory back to the master, one bit per serial clock. The block also drives an output-enable so that the chip pad can tri-state the serial output whenever the block is not sending.

A transaction opens when chip select falls. The master sends a command byte and then an address byte, MSB first. The top address bit rides inside the command byte. After that, every falling serial-clock edge presents the next data bit. The address steps after each byte and wraps from the top location to zero, so one command can sweep the array any number of times. If the write-busy input is high when the command byte completes, the command is refused. A preload port fills the memory from the system side.

Top module: `spi_eeprom_reader`

## Requirements
- R1: After a synchronous reset, so_oe is 0.
- R2: Serial input bits are sampled on rising spi_sclk edges, MSB first. The first byte after chip select falls is the command byte and the second is the address byte. A command is a read when bits 7..4 are 0000 and bits 2..0 are 011, whatever bit 3 is.
- R3: The start address is {command bit 3, address byte} truncated to AW bits.
- R4: Each data byte goes out MSB first. Each bit changes only after a falling spi_sclk edge. The first data bit follows the falling edge after the last address bit.
- R5: While chip select stays low, the byte at the next address follows each byte with no further command.
- R6: After the byte at address 2^AW-1, the stream continues at address 0.
- R7: A rising spi_cs_n ends the transaction at any bit position. so_oe is 0 within 6 clk cycles, and the next transaction decodes from scratch.
- R8: so_oe is 0 throughout the command and address bytes.
- R9: If wr_busy is 1 when the eighth command bit is sampled, the read is refused and so_oe stays 0 until spi_cs_n rises.
- R10: Any command byte other than a read leaves so_oe at 0 until spi_cs_n rises.
- R11: When ld_we is 1 on a clk edge, ld_data is stored at ld_addr and later read back by a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| wr_busy | input | 1 | High while a write cycle is in progress |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | AW | Preload address |
| ld_data | input | 8 | Preload byte |
| so_data | output | 1 | Serial data toward the pad |
| so_oe | output | 1 | Output enable for the tri-state pad |

## Verification
The assertions assume that every serial-clock level and every chip-select level lasts several system clocks, so that the two-flop synchroniser never merges or drops an edge. They also assume that chip select rises only while the serial clock is low or falling. The stimulus holds each serial-clock half period for eight system clocks. It changes data only together with falling edges, and it opens each frame one half period before the first rising edge. It raises chip select in the same instant as the last falling edge, which also covers a stop partway through a byte.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CMD    = 3'd1,
    ST_ADDR   = 3'd2,
    ST_STREAM = 3'd3,
    ST_REFUSE = 3'd4
  } rd_state_e;

  localparam logic [3:0] RD_OP_HI = 4'b0000;
  localparam logic [2:0] RD_OP_LO = 3'b011;

  function automatic logic is_read_cmd(input logic [7:0] cmd);
    return (cmd[7:4] == RD_OP_HI) && (cmd[2:0] == RD_OP_LO);
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RST_VAL;
          else     pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= RST_VAL;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= RST_VAL;
    else     q_prev <= pipe[STAGES-1];
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine
  import spi_eeprom_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic          wr_busy,
  input  logic [7:0]    ram_q,
  output logic [AW-1:0] rd_addr,
  output logic          so_data,
  output logic          so_oe,
  output rd_state_e     state_o
);

  localparam int FULL_AW = 9;

  rd_state_e       state;
  logic [2:0]      bit_cnt;
  logic [7:0]      in_sr;
  logic [7:0]      out_sr;
  logic            hi_bit;
  logic [7:0]      in_next;
  logic [FULL_AW-1:0] full_addr;

  assign in_next   = {in_sr[6:0], mosi_s};
  assign full_addr = {hi_bit, in_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
      hi_bit  <= 1'b0;
      rd_addr <= '0;
      so_data <= 1'b0;
      so_oe   <= 1'b0;
    end else if (cs_n_s) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      so_oe   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state   <= ST_CMD;
          bit_cnt <= '0;
        end
        ST_CMD: begin
          if (sclk_rise) begin
            in_sr   <= in_next;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (is_read_cmd(in_next) && !wr_busy) begin
                hi_bit <= in_next[3];
                state  <= ST_ADDR;
              end else begin
                state  <= ST_REFUSE;
              end
            end
          end
        end
        ST_ADDR: begin
          if (sclk_rise) begin
            in_sr   <= in_next;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              rd_addr <= full_addr[AW-1:0];
              state   <= ST_STREAM;
            end
          end
        end
        ST_STREAM: begin
          if (sclk_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            so_oe   <= 1'b1;
            if (bit_cnt == 3'd0) begin
              so_data <= ram_q[7];
              out_sr  <= {ram_q[6:0], 1'b0};
              rd_addr <= rd_addr + 1'b1;
            end else begin
              so_data <= out_sr[7];
              out_sr  <= {out_sr[6:0], 1'b0};
            end
          end
        end
        default: begin
          so_oe <= 1'b0;
        end
      endcase
    end
  end

  assign state_o = state;

endmodule

// File: rtl/spi_eeprom_reader.sv
module spi_eeprom_reader
  import spi_eeprom_pkg::*;
#(
  parameter int AW      = 9,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          wr_busy,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic          so_data,
  output logic          so_oe
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b010;

  logic [NSIG-1:0] sync_q;
  logic [NSIG-1:0] sync_prev;
  logic            sclk_rise;
  logic            sclk_fall;
  logic [7:0]      ram_q;
  logic [AW-1:0]   rd_addr_w;
  rd_state_e       state_w;

  spi_in_sync #(
    .W       (NSIG),
    .STAGES  (SYNC_ST),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    ({spi_mosi, spi_cs_n, spi_sclk}),
    .q      (sync_q),
    .q_prev (sync_prev)
  );

  assign sclk_rise =  sync_q[0] & ~sync_prev[0];
  assign sclk_fall = ~sync_q[0] &  sync_prev[0];

  spi_byte_ram #(
    .AW (AW),
    .DW (8)
  ) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr_w),
    .rdata (ram_q)
  );

  spi_read_engine #(
    .AW (AW)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (sync_q[1]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (sync_q[2]),
    .wr_busy   (wr_busy),
    .ram_q     (ram_q),
    .rd_addr   (rd_addr_w),
    .so_data   (so_data),
    .so_oe     (so_oe),
    .state_o   (state_w)
  );

endmodule

// File: rtl/spi_eeprom_reader_chk.sv
module spi_eeprom_reader_chk
  import spi_eeprom_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          spi_cs_n,
  input logic          so_oe,
  input rd_state_e     state,
  input logic [AW-1:0] rd_addr
);

  p_oe_off_after_reset_r1: assert property (@(posedge clk)
    rst |=> !so_oe);

  p_oe_after_addr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> ($past(state) == ST_STREAM));

  // R6: the AW-bit sum also covers the step from the top address to zero
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STREAM && $past(state) == ST_STREAM && rd_addr != $past(rd_addr))
      |-> (rd_addr == $past(rd_addr) + AW'(1)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !so_oe);

  p_quiet_in_header_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD || state == ST_ADDR || state == ST_REFUSE) |-> !so_oe);

endmodule

bind spi_eeprom_reader spi_eeprom_reader_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_cs_n (spi_cs_n),
  .so_oe    (so_oe),
  .state    (state_w),
  .rd_addr  (rd_addr_w)
);

// File: tb/test_spi_eeprom_reader.sv
module test_spi_eeprom_reader;

  localparam int AW   = 9;
  localparam int HALF = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_sclk = 1'b0;
  logic          spi_cs_n = 1'b1;
  logic          spi_mosi = 1'b0;
  logic          wr_busy = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic          so_data;
  logic          so_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // monitor phase: 0 off, 1 header (oe must be 0), 2 data, 3 refused (oe must be 0)
  int          mon_phase = 0;
  string       mon_tag = "R8";
  int          mon_bits = 0;
  logic [7:0]  mon_sr = '0;
  logic [7:0]  exp_q [$];

  always #4 clk = ~clk;

  spi_eeprom_reader #(.AW(AW)) i_spi_eeprom_reader (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .wr_busy  (wr_busy),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .so_data  (so_data),
    .so_oe    (so_oe)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C ^ (a[8] ? 8'hA5 : 8'h00);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // monitor: samples at each rising serial clock, away from clk edges
  always @(posedge spi_sclk) begin
    if (mon_phase == 1) begin
      check(so_oe == 1'b0, "R8 oe in header", so_oe, 0);
    end else if (mon_phase == 3) begin
      check(so_oe == 1'b0, mon_tag, so_oe, 0);
    end else if (mon_phase == 2) begin
      check(so_oe == 1'b1, "R4 oe in data", so_oe, 1);
      mon_sr = {mon_sr[6:0], so_data};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected byte", mon_sr, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_sr == e, mon_tag, mon_sr, e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b);
    spi_sclk = 1'b0;
    spi_mosi = b;
    wait_clk(HALF);
    spi_sclk = 1'b1;
    wait_clk(HALF);
  endtask

  // driver: sends command+address, pushes expected bytes, clocks the data phase
  task automatic txn(input logic [7:0] cmd, input logic [7:0] abyte, input bit accept,
                     input int nbytes, input int extra_bits, input string tag);
    logic [AW-1:0] a;
    a = AW'({cmd[3], abyte});
    mon_bits  = 0;
    mon_sr    = '0;
    mon_phase = 1;
    spi_cs_n  = 1'b0;
    for (int i = 7; i >= 0; i--) spi_bit(cmd[i]);
    for (int i = 7; i >= 0; i--) spi_bit(abyte[i]);
    mon_tag = tag;
    if (accept) begin
      for (int k = 0; k < nbytes; k++) exp_q.push_back(pat(a + AW'(k)));
      mon_phase = 2;
    end else begin
      mon_phase = 3;
    end
    for (int k = 0; k < nbytes * 8 + extra_bits; k++) spi_bit(1'b0);
    wait_clk(HALF);
    if (accept && extra_bits > 0) begin
      logic [7:0] full;
      logic [7:0] mask;
      full = pat(a + AW'(nbytes));
      mask = 8'hFF << (8 - extra_bits);
      check((mon_sr & (8'hFF >> (8 - extra_bits))) == ((full & mask) >> (8 - extra_bits)),
            "R7 partial bits", mon_sr, full);
    end
    spi_sclk  = 1'b0;
    spi_cs_n  = 1'b1;
    mon_phase = 0;
    wait_clk(6);
    check(so_oe == 1'b0, "R7 oe released", so_oe, 0);
    check(exp_q.size() == 0, "R5 bytes outstanding", exp_q.size(), 0);
    exp_q.delete();
    wait_clk(4 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);

    // R11 preload every address
    for (int a = 0; a < (1 << AW); a++) begin
      ld_we   = 1'b1;
      ld_addr = AW'(a);
      ld_data = pat(AW'(a));
      wait_clk(1);
    end
    ld_we = 1'b0;
    wait_clk(4);

    // R2 R3 R11: low half, three bytes
    txn(8'h03, 8'h05, 1'b1, 3, 0, "R2 read low half");
    // R3: bit 3 of command supplies A8
    txn(8'h0B, 8'hF0, 1'b1, 2, 0, "R3 read with A8 set");
    // R4 R5: longer stream mid array
    txn(8'h03, 8'h7D, 1'b1, 5, 0, "R5 streaming");
    // R6: wrap past top address
    txn(8'h0B, 8'hFE, 1'b1, 4, 0, "R6 wrap to zero");
    // R7: abort in the middle of a byte, then a clean read
    txn(8'h03, 8'h40, 1'b1, 1, 3, "R7 before abort");
    txn(8'h03, 8'h41, 1'b1, 1, 0, "R7 after abort");
    // R9: refused while busy
    wr_busy = 1'b1;
    txn(8'h03, 8'h10, 1'b0, 2, 0, "R9 refused busy");
    wr_busy = 1'b0;
    // R10: other command codes
    txn(8'h02, 8'h10, 1'b0, 2, 0, "R10 write code ignored");
    txn(8'h83, 8'h10, 1'b0, 1, 0, "R10 high bit ignored");
    txn(8'h07, 8'h10, 1'b0, 1, 0, "R10 low bits ignored");
    // R9: busy clear again accepts
    txn(8'h03, 8'h10, 1'b1, 1, 0, "R9 accepted idle");
    summary();
  end

endmodule